// File: doc/BRIEF.md
# SRAM-FPGA Configuration Loader with Power-Up Sequencing

This block brings up an SRAM-based companion device whose configuration is lost every time its supplies are removed. Before the supplies come up, it drives the device's chip select low so that the device boots as an SPI slave. It then raises the I/O rail, the core rail and the reference clock together. After a fixed hold time it releases chip select for one SCLK period. The configuration image is then streamed byte by byte from a ready/valid source, followed by a fixed burst of extra clocks. Finally the block waits a bounded time for the device's config-done pin.

The device's reset line stays asserted for the whole sequence. The block releases it only once config-done has been seen, and by then the reference clock has been enabled. If config-done does not arrive within the limit, the block powers the device down, returns to idle and raises a timeout flag. A start pulse begins a sequence from idle or from the done state; a start pulse during a sequence is ignored. A microsecond prescaler, derived from the system clock parameter, times the long waits.

Top module: `cfg_loader`

## Requirements
- R1: Out of reset, the target reset output is low, all three enables are low, chip select is high, SCLK and MOSI are low, image ready is low, and busy, done and timeout are all low.
- R2: The cycle after a start is accepted, chip select is low while all enables are still low. The enables rise on the following cycle.
- R3: The I/O rail enable, the core rail enable and the reference clock enable rise together, and stay high until the sequence ends in done or timeout.
- R4: Once the enables rise, chip select stays low for exactly CS_HOLD_US × CLK_HZ/1e6 cycles (6250 at the defaults). It is then high for exactly one SCLK period before the image transfer pulls it low again.
- R5: SCLK idles low. Each high phase and each low phase lasts HALF = ceil(CLK_HZ / (2 × SCLK_MAX_HZ)) cycles, which is 3 cycles (about 20.8 MHz) at the defaults. SCLK toggles only while chip select is low.
- R6: Each image byte goes out MSB first. MOSI takes bit 7 when the byte is accepted and moves to the next bit only when SCLK falls. MOSI is low when no byte is being shifted.
- R7: A byte is taken on a clock edge where img_ready_o and img_valid_i are both high. img_ready_o is high only in the transfer phase when no byte, dummy clock or completion is pending. While valid is low, SCLK stays low.
- R8: After the last bit of the byte marked with img_last_i, exactly DUMMY_CLKS (49) more SCLK pulses are produced with chip select low. Chip select then goes high and SCLK stays low.
- R9: The target reset output is released only in the done state, and only while the reference clock enable has been high since the cycle before.
- R10: cfg_done_i passes through a SYNC_STAGES-flop synchronizer (2 by default). When it is seen high during the wait phase, the next cycle shows done_o high, busy_o low and the target out of reset.
- R11: If cfg_done_i is not seen within DONE_TIMEOUT_US microseconds (25000 cycles at the defaults), the block returns to idle with all enables low and chip select high, and timeout_o rises.
- R12: A start pulse while busy_o is high has no effect on any output.
- R13: A start pulse from idle or from the done state begins a new sequence and clears timeout_o on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a load sequence (one-cycle pulse) |
| img_data_i | input | 8 | Configuration image byte |
| img_valid_i | input | 1 | Image byte is present |
| img_last_i | input | 1 | Present byte is the final byte of the image |
| img_ready_o | output | 1 | Loader can accept a byte this cycle |
| cfg_done_i | input | 1 | Config-done pin of the target (asynchronous) |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| vio_en_o | output | 1 | I/O rail enable |
| vcore_en_o | output | 1 | Core rail enable |
| refclk_en_o | output | 1 | Reference clock enable |
| cs_n_o | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Target configured and out of reset |
| timeout_o | output | 1 | Last sequence failed on the config-done limit |

## Verification
A phase register that sits in the wrong state shows at the pins on the very next cycle: the pin outputs are decoded from the next state, so chip select, the rails or busy move one edge early or late. A miscount in the hold, gap, dummy or timeout counters moves a chip-select or status edge by at least one cycle. A fault in the bit engine shows as a misplaced SCLK edge or a wrong MOSI level within one half period. The bench runs a behavioural timing model beside the design and compares every output on every cycle. It also counts SCLK pulses and captures MOSI on each rising edge, independently of that model, so errors in bit order and dummy count are reported at the first wrong bit.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CSPRE = 3'd1,
      ST_PWR   = 3'd2,
      ST_GAP   = 3'd3,
      ST_LOAD  = 3'd4,
      ST_WAIT  = 3'd5,
      ST_DONE  = 3'd6
   } ld_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r <= '0;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_us_tick.sv
module cfg_us_tick #(
   parameter int CLK_HZ = 125_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int DIV = CLK_HZ / 1_000_000;
   localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)               cnt <= '0;
            else if (cnt == CW'(DIV - 1))    cnt <= '0;
            else                             cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/cfg_bit_engine.sv
module cfg_bit_engine #(
   parameter int HALF       = 3,
   parameter int DUMMY_CLKS = 49
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       byte_valid,
   input  logic [7:0] byte_data,
   input  logic       byte_last,
   output logic       byte_ready,
   output logic       sclk,
   output logic       mosi,
   output logic       fin
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int DW = $clog2(DUMMY_CLKS + 1);

   logic [HW-1:0] hc;
   logic [DW-1:0] dcnt;
   logic [7:0]    sh;
   logic [2:0]    bits;
   logic          have, last_q, dum, sclk_q, fin_q;
   logic          half_end;

   assign half_end = (hc == HW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         hc <= '0; dcnt <= '0; sh <= '0; bits <= '0;
         have <= 1'b0; last_q <= 1'b0; dum <= 1'b0;
         sclk_q <= 1'b0; fin_q <= 1'b0;
      end else if (!have && !dum) begin
         if (!fin_q && byte_valid) begin
            sh     <= byte_data;
            last_q <= byte_last;
            have   <= 1'b1;
            bits   <= '0;
            hc     <= '0;
         end
      end else if (!half_end) begin
         hc <= hc + 1'b1;
      end else begin
         hc     <= '0;
         sclk_q <= ~sclk_q;
         if (sclk_q) begin
            if (have) begin
               if (bits == 3'd7) begin
                  have <= 1'b0;
                  if (last_q) begin
                     dum  <= 1'b1;
                     dcnt <= '0;
                  end
               end else begin
                  bits <= bits + 1'b1;
                  sh   <= {sh[6:0], 1'b0};
               end
            end else if (dcnt == DW'(DUMMY_CLKS - 1)) begin
               dum   <= 1'b0;
               fin_q <= 1'b1;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

   assign byte_ready = en && !have && !dum && !fin_q;
   assign sclk       = sclk_q;
   assign mosi       = have && sh[7];
   assign fin        = fin_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int CLK_HZ          = 125_000_000,
   parameter int SCLK_MAX_HZ     = 25_000_000,
   parameter int CS_HOLD_US      = 50,
   parameter int DUMMY_CLKS      = 49,
   parameter int DONE_TIMEOUT_US = 200,
   parameter int SYNC_STAGES     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] img_data_i,
   input  logic       img_valid_i,
   input  logic       img_last_i,
   output logic       img_ready_o,
   input  logic       cfg_done_i,
   output logic       tgt_rst_n_o,
   output logic       vio_en_o,
   output logic       vcore_en_o,
   output logic       refclk_en_o,
   output logic       cs_n_o,
   output logic       sclk_o,
   output logic       mosi_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       timeout_o
);
   localparam int HALF    = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
   localparam int GAP_CYC = 2 * HALF;
   localparam int GW      = $clog2(GAP_CYC + 1);
   localparam int UW      = $clog2(max2(CS_HOLD_US, DONE_TIMEOUT_US) + 1);

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("cfg_loader: CLK_HZ must be a whole number of MHz");
      end
      if (SCLK_MAX_HZ < 1) begin : g_bad_sclk
         $error("cfg_loader: SCLK_MAX_HZ must be positive");
      end
      if (CS_HOLD_US < 1 || DONE_TIMEOUT_US < 1) begin : g_bad_time
         $error("cfg_loader: time limits must be at least 1 us");
      end
      if (DUMMY_CLKS < 1) begin : g_bad_dummy
         $error("cfg_loader: DUMMY_CLKS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cfg_loader: SYNC_STAGES out of range 0..4");
      end
   endgenerate

   ld_state_t     state, nxt;
   logic          tick, clr, done_s, fin;
   logic [UW-1:0] us_cnt;
   logic [GW-1:0] cyc;
   logic          cs_n_q, pwr_q, trst_q, busy_q, done_q, to_q;

   cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cfg_done_i), .q(done_s)
   );

   cfg_us_tick #(.CLK_HZ(CLK_HZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
   );

   cfg_bit_engine #(.HALF(HALF), .DUMMY_CLKS(DUMMY_CLKS)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(state == ST_LOAD),
      .byte_valid(img_valid_i), .byte_data(img_data_i), .byte_last(img_last_i),
      .byte_ready(img_ready_o), .sclk(sclk_o), .mosi(mosi_o), .fin(fin)
   );

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start_i) nxt = ST_CSPRE;
         ST_CSPRE: nxt = ST_PWR;
         ST_PWR:   if (tick && us_cnt == UW'(CS_HOLD_US - 1)) nxt = ST_GAP;
         ST_GAP:   if (cyc == GW'(GAP_CYC - 1)) nxt = ST_LOAD;
         ST_LOAD:  if (fin) nxt = ST_WAIT;
         ST_WAIT:  if (done_s) nxt = ST_DONE;
                   else if (tick && us_cnt == UW'(DONE_TIMEOUT_US - 1)) nxt = ST_IDLE;
         ST_DONE:  if (start_i) nxt = ST_CSPRE;
         default:  nxt = ST_IDLE;
      endcase
   end

   assign clr = (nxt != state);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         us_cnt <= '0;
         cyc    <= '0;
         to_q   <= 1'b0;
      end else begin
         state  <= nxt;
         us_cnt <= clr ? '0 : (tick ? us_cnt + 1'b1 : us_cnt);
         cyc    <= clr ? '0 : cyc + 1'b1;
         if (state == ST_WAIT && nxt == ST_IDLE)
            to_q <= 1'b1;
         else if ((state == ST_IDLE || state == ST_DONE) && start_i)
            to_q <= 1'b0;
      end
   end

   // pins decoded from the next state so every pin leaves a flop
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n_q <= 1'b1;
         pwr_q  <= 1'b0;
         trst_q <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         cs_n_q <= !(nxt inside {ST_CSPRE, ST_PWR, ST_LOAD});
         pwr_q  <= nxt inside {ST_PWR, ST_GAP, ST_LOAD, ST_WAIT, ST_DONE};
         trst_q <= (nxt == ST_DONE);
         busy_q <= nxt inside {ST_CSPRE, ST_PWR, ST_GAP, ST_LOAD, ST_WAIT};
         done_q <= (nxt == ST_DONE);
      end
   end

   assign cs_n_o      = cs_n_q;
   assign vio_en_o    = pwr_q;
   assign vcore_en_o  = pwr_q;
   assign refclk_en_o = pwr_q;
   assign tgt_rst_n_o = trst_q;
   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign timeout_o   = to_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic img_ready_o,
   input logic tgt_rst_n_o,
   input logic vio_en_o,
   input logic refclk_en_o,
   input logic cs_n_o,
   input logic sclk_o,
   input logic mosi_o,
   input logic busy_o,
   input logic done_o,
   input logic timeout_o
);
   a_r2_cs_low_before_rails: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vio_en_o) |-> (!cs_n_o && $past(!cs_n_o)));

   a_r5_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !cs_n_o);

   a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   a_r7_ready_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
      img_ready_o |-> !sclk_o);

   a_r9_release_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst_n_o |-> (refclk_en_o && $past(refclk_en_o)));

   a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o, timeout_o}));

   a_r11_timeout_powered_off: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!vio_en_o && !tgt_rst_n_o && cs_n_o));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
   .clk(clk), .rst_n(rst_n), .img_ready_o(img_ready_o), .tgt_rst_n_o(tgt_rst_n_o),
   .vio_en_o(vio_en_o), .refclk_en_o(refclk_en_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
   .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
   localparam int CLK_HZ = 125_000_000;
   localparam int SCLK_MAX = 25_000_000;
   localparam int HOLD = 50;
   localparam int DUMMY = 49;
   localparam int TOUT = 200;
   localparam int SYNC = 2;
   localparam int DIV = CLK_HZ / 1_000_000;
   localparam int HALF = (CLK_HZ + 2 * SCLK_MAX - 1) / (2 * SCLK_MAX);

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [7:0] img_data_i = 8'h00;
   logic img_valid_i = 1'b0, img_last_i = 1'b0, cfg_done_i = 1'b0;
   logic img_ready_o, tgt_rst_n_o, vio_en_o, vcore_en_o, refclk_en_o;
   logic cs_n_o, sclk_o, mosi_o, busy_o, done_o, timeout_o;

   always #4 clk = ~clk;

   cfg_loader u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_data_i(img_data_i),
      .img_valid_i(img_valid_i), .img_last_i(img_last_i), .img_ready_o(img_ready_o),
      .cfg_done_i(cfg_done_i), .tgt_rst_n_o(tgt_rst_n_o), .vio_en_o(vio_en_o),
      .vcore_en_o(vcore_en_o), .refclk_en_o(refclk_en_o), .cs_n_o(cs_n_o),
      .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o),
      .timeout_o(timeout_o)
   );

   int n_chk = 0, n_err = 0;
   bit mon_on = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural timing model ----------------
   int ph = 0, t = 0, e = 0, de = 0;
   bit m_have = 0, m_dum = 0, m_fin = 0, m_to = 0, m_last = 0, use_d;
   logic [7:0] m_byte = 8'h00;
   bit hist [SYNC];

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; t = 0; m_to = 0; m_have = 0; m_dum = 0; m_fin = 0;
         for (int k = 0; k < SYNC; k++) hist[k] = 0;
      end else begin
         use_d = hist[SYNC-1];
         for (int k = SYNC - 1; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = cfg_done_i;
         case (ph)
            0: if (start_i) begin ph = 1; m_to = 0; end
            1: begin ph = 2; t = 0; end
            2: if (t == HOLD * DIV - 1) begin ph = 3; t = 0; end else t++;
            3: if (t == 2 * HALF - 1) begin
                  ph = 4; m_have = 0; m_dum = 0; m_fin = 0;
               end else t++;
            4: if (m_fin) begin ph = 5; t = 0; end
               else if (!m_have && !m_dum) begin
                  if (img_valid_i) begin
                     m_have = 1; e = 0; m_byte = img_data_i; m_last = img_last_i;
                  end
               end else if (m_have) begin
                  e++;
                  if (e == 16 * HALF) begin
                     m_have = 0;
                     if (m_last) begin m_dum = 1; de = 0; end
                  end
               end else begin
                  de++;
                  if (de == 2 * HALF * DUMMY) begin m_dum = 0; m_fin = 1; end
               end
            5: if (use_d) ph = 6;
               else if (t == TOUT * DIV - 1) begin ph = 0; m_to = 1; end
               else t++;
            6: if (start_i) begin ph = 1; m_to = 0; end
            default: ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (mon_on) begin
         bit up;
         bit ex_sclk, ex_mosi;
         up = (ph >= 2);
         ex_sclk = (ph == 4 && m_have) ? ((e / HALF) % 2 == 1) :
                   (ph == 4 && m_dum)  ? ((de / HALF) % 2 == 1) : 1'b0;
         ex_mosi = (ph == 4 && m_have) ? m_byte[7 - e / (2 * HALF)] : 1'b0;
         chk("R4 cs_n", cs_n_o, !(ph == 1 || ph == 2 || ph == 4));
         chk("R3 vio_en", vio_en_o, up);
         chk("R3 vcore_en", vcore_en_o, up);
         chk("R3 refclk_en", refclk_en_o, up);
         chk("R9 tgt_rst_n", tgt_rst_n_o, ph == 6);
         chk("R5 sclk", sclk_o, ex_sclk);
         chk("R6 mosi", mosi_o, ex_mosi);
         chk("R7 img_ready", img_ready_o, ph == 4 && !m_have && !m_dum && !m_fin);
         chk("R12 busy", busy_o, ph >= 1 && ph <= 5);
         chk("R10 done", done_o, ph == 6);
         chk("R11 timeout", timeout_o, m_to);
      end
   end

   // ---------------- independent pin monitor ----------------
   logic [7:0] img [16];
   int n_img = 0, rises = 0, hi_len = 0, hold = 0;
   bit psclk = 0, pvio = 0, pcs = 1, meas = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         if (vio_en_o && !pvio) begin
            chk("R2 cs low before rails", pcs, 1'b0);
            meas = 1; hold = 0;
         end
         if (meas) begin
            if (!cs_n_o) hold++;
            else begin chk("R4 hold cycles", hold, HOLD * DIV); meas = 0; end
         end
         if (sclk_o && !psclk) begin
            rises++;
            if (rises <= 8 * n_img)
               chk("R6 msb-first bit", mosi_o, img[(rises - 1) / 8][7 - (rises - 1) % 8]);
         end
         if (sclk_o) hi_len++;
         else if (psclk) begin chk("R5 high width", hi_len, HALF); hi_len = 0; end
         psclk = sclk_o; pvio = vio_en_o; pcs = cs_n_o;
      end
   end

   // ---------------- stimulus ----------------
   task automatic feed(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         bit ok;
         img_valid_i = 1'b1; img_data_i = img[i]; img_last_i = (i == n - 1);
         do begin ok = img_ready_o; @(negedge clk); end while (!ok);
         img_valid_i = 1'b0; img_last_i = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
   endtask

   task automatic wait_ph(input int p);
      while (ph != p) @(negedge clk);
   endtask

   task automatic set_img(input int n, input int seed);
      n_img = n; rises = 0;
      for (int i = 0; i < n; i++) img[i] = 8'((i * 73 + seed) ^ (i << 5));
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd >= 190000) begin
         n_err++;
         $display("FAIL watchdog actual=%0d expected<%0d", wd, 190000);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 tgt_rst_n", tgt_rst_n_o, 0); chk("R1 vio_en", vio_en_o, 0);
      chk("R1 cs_n", cs_n_o, 1); chk("R1 sclk", sclk_o, 0);
      chk("R1 status", {busy_o, done_o, timeout_o, img_ready_o}, 0);
      rst_n = 1'b1; mon_on = 1'b1;
      @(negedge clk);

      // Run A: continuous image, spurious start while busy, done after a delay
      set_img(5, 8'h5A);
      pulse_start();
      chk("R2 cs first", {cs_n_o, vio_en_o}, 2'b00);
      fork
         feed(5, 0);
         begin
            repeat (100) @(negedge clk);
            pulse_start();
            chk("R12 start ignored rails", {vio_en_o, cs_n_o, busy_o}, 3'b101);
         end
      join
      wait_ph(5);
      repeat (300) @(negedge clk);
      cfg_done_i = 1'b1;
      wait_ph(6);
      repeat (3) @(negedge clk);
      chk("R8 pulse count A", rises, 8 * 5 + DUMMY);
      chk("R10 done A", {done_o, busy_o, tgt_rst_n_o}, 3'b101);

      // Run B: restart from done, gappy source, no config-done -> timeout
      cfg_done_i = 1'b0;
      set_img(3, 8'hC3);
      pulse_start();
      chk("R13 restart from done", {cs_n_o, vio_en_o, done_o, busy_o}, 4'b0001);
      feed(3, 7);
      wait_ph(0);
      @(negedge clk);
      chk("R8 pulse count B", rises, 8 * 3 + DUMMY);
      chk("R11 timeout state", {timeout_o, vio_en_o, cs_n_o, busy_o}, 4'b1010);

      // Run C: restart after timeout, config-done raised early
      set_img(2, 8'h11);
      pulse_start();
      chk("R13 timeout cleared", timeout_o, 0);
      feed(2, 0);
      cfg_done_i = 1'b1;
      wait_ph(6);
      repeat (2) @(negedge clk);
      chk("R8 pulse count C", rises, 8 * 2 + DUMMY);
      chk("R10 done C", {done_o, tgt_rst_n_o, refclk_en_o}, 3'b111);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule